// File: doc/BRIEF.md
# UART Receiver with Address Filtering

This block receives asynchronous serial frames on a single line and hands each one over as a parallel byte. The frame is either 8 or 9 data-bearing bits long. A start bit comes first and a stop bit comes last. An external 16x oversampling tick sets the bit timing. Each bit is decided by a two-of-three vote over the samples at the middle of the bit. A start bit that does not survive the vote is treated as line noise, and the receiver goes back to waiting.

Two additions serve shared multiprocessor buses.

- **Framing errors.** A stop bit that reads low raises a framing error flag. The flag stays set until software clears it with a strobe. Later good frames do not clear it.
- **Address filtering.** When multiprocessor filtering is enabled, a frame is handed over only if two conditions hold:
  - Its address marker is 1. The marker is the ninth bit in 9-bit mode and the stop bit in 8-bit mode.
  - Its byte matches a programmable slave address in every bit position selected by a mask, or it equals the broadcast address.

  A rejected frame leaves the data, the ninth bit and the receive-complete flag as they were.

Top module: `serial_rx_addrfilt`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_bit9` is 0, `rx_done` is 0 and `frame_err` is 0.
- R2: A frame is a low start bit, followed by the data bits LSB first, followed by the stop bit. Each bit lasts 16 baud ticks. Outputs update on the clock edge that takes the tenth tick (tick index 9) of the stop bit.
- R3: With `nine_bit_mode` = 1, the bit after the eighth data bit is the ninth bit. When the frame is accepted, it is placed on `rx_bit9`.
- R4: With `nine_bit_mode` = 0, an accepted frame places the stop bit value on `rx_bit9`.
- R5: The start bit is judged by a majority of the samples at tick indices 7, 8 and 9. If the majority is 1, reception is abandoned, nothing changes, and the receiver waits for a new falling edge.
- R6: A stop bit whose majority is 0 sets `frame_err`. The flag stays set through later frames with valid stop bits.
- R7: `frame_err` drops only one edge after a `fe_clr` pulse. If a framing error arrives on the same edge as `fe_clr`, the flag is set.
- R8: An accepted frame sets `rx_done`. `done_clr` clears it, except on an edge where a frame is accepted; there the set wins.
- R9: With `mp_en` = 1, a frame whose address marker is 0 leaves `rx_data`, `rx_bit9` and `rx_done` unchanged. The address marker is the ninth bit in 9-bit mode and the stop bit in 8-bit mode.
- R10: With `mp_en` = 1 and the marker at 1, a byte is accepted when it equals `slave_addr` at every position where `addr_mask` is 1. A mismatch at such a position rejects the frame.
- R11: With `mp_en` = 1 and the marker at 1, a byte equal to `slave_addr | addr_mask` is accepted even when the masked comparison fails.
- R12: In 8-bit mode with `mp_en` = 1, a frame with a low stop bit is rejected as an address frame, yet still sets `frame_err`.
- R13: Each data bit is decided by the majority of its samples at tick indices 7, 8 and 9. A single inverted sample does not change the received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| nine_bit_mode | input | 1 | 1 selects 9-bit frames, 0 selects 8-bit frames |
| mp_en | input | 1 | Enables address filtering |
| slave_addr | input | 8 | Own slave address |
| addr_mask | input | 8 | 1 marks address bits that are compared |
| done_clr | input | 1 | Clear strobe for `rx_done` |
| fe_clr | input | 1 | Clear strobe for `frame_err` |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit, or stop bit in 8-bit mode, of the last accepted frame |
| rx_done | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Sticky framing error flag |

## Verification
The hardest situation to reach from the ports is a clear strobe that lands on the very edge where a frame completes. Only that case shows whether set or clear wins. The bench drives the line one tick at a time and raises both strobes together with the stop bit's tenth tick.

Since every tick carries a chosen line value, the individual vote samples can also be corrupted. The bench flips one mid-bit sample of a data bit, and cuts a start bit short so that its vote fails. The recovery from that cut is then shown by a clean frame that follows it.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } srx_state_e;

  // two-of-three majority
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = din;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          nine_bit,
  output logic          frm_valid,
  output logic [DW-1:0] frm_data,
  output logic          frm_ninth,
  output logic          frm_stop_ok
);

  localparam int CW     = $clog2(OSR);
  localparam int IW     = $clog2(DW + 1);
  localparam int SMP_A  = OSR / 2 - 1;
  localparam int SMP_B  = OSR / 2;
  localparam int SMP_C  = OSR / 2 + 1;
  localparam int LAST_T = OSR - 1;

  srx_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [1:0]    smp_q, smp_d;
  logic [DW:0]   shift_q, shift_d;

  logic          vote;
  logic          at_a, at_b, at_c, at_last;
  logic [IW-1:0] last_idx;

  assign at_a     = (cnt_q == CW'(SMP_A));
  assign at_b     = (cnt_q == CW'(SMP_B));
  assign at_c     = (cnt_q == CW'(SMP_C));
  assign at_last  = (cnt_q == CW'(LAST_T));
  assign vote     = vote3(smp_q[0], smp_q[1], rxd_s);
  assign last_idx = nine_bit ? IW'(DW) : IW'(DW - 1);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    smp_d       = smp_q;
    shift_d     = shift_q;
    frm_valid   = 1'b0;
    frm_stop_ok = vote;
    frm_ninth   = nine_bit ? shift_q[DW] : vote;
    if (tick) begin
      if (state_q != ST_IDLE) begin
        cnt_d = cnt_q + CW'(1);
        if (at_a) smp_d[0] = rxd_s;
        if (at_b) smp_d[1] = rxd_s;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (!rxd_s) begin
            state_d = ST_START;
            cnt_d   = CW'(1);
          end
        end
        ST_START: begin
          if (at_c && vote) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else if (at_last) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            idx_d   = '0;
          end
        end
        ST_DATA: begin
          if (at_c) shift_d[idx_q] = vote;
          if (at_last) begin
            cnt_d = '0;
            if (idx_q == last_idx) state_d = ST_STOP;
            else                   idx_d   = idx_q + IW'(1);
          end
        end
        ST_STOP: begin
          if (at_c) begin
            frm_valid = 1'b1;
            state_d   = ST_IDLE;
            cnt_d     = '0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      smp_q   <= '0;
      shift_q <= '0;
    end else if (tick) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      smp_q   <= smp_d;
      shift_q <= shift_d;
    end
  end

  assign frm_data = shift_q[DW-1:0];

  // R2: bit timing advances only on baud ticks
  a_r2_cnt_holds_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R2: a completed frame is reported for exactly one cycle
  a_r2_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  // R5: a start bit voted high returns to idle
  a_r5_start_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && at_c && rxd_s && smp_q[0] && smp_q[1])
      |=> (state_q == ST_IDLE));

endmodule

// File: rtl/srx_addr_match.sv
module srx_addr_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] cmp_mask,
  output logic          hit
);

  logic [DW-1:0] diff;
  logic [DW-1:0] bcast_eq;

  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_bit
      assign diff[i]     = cmp_mask[i] & (rx_byte[i] ^ own_addr[i]);
      assign bcast_eq[i] = (rx_byte[i] == (own_addr[i] | cmp_mask[i]));
    end
  endgenerate

  assign hit = ~|diff | &bcast_eq;

endmodule

// File: rtl/serial_rx_addrfilt.sv
module serial_rx_addrfilt
  import srx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          baud_tick,
  input  logic          nine_bit_mode,
  input  logic          mp_en,
  input  logic [DW-1:0] slave_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          done_clr,
  input  logic          fe_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_done,
  output logic          frame_err
);

  logic          rst_n_i;
  logic          rxd_s;
  logic          frm_valid;
  logic [DW-1:0] frm_data;
  logic          frm_ninth;
  logic          frm_stop_ok;
  logic          addr_hit;
  logic          accept;

  logic [DW-1:0] data_q, data_d;
  logic          b9_q, b9_d;
  logic          done_q, done_d;
  logic          fe_q, fe_d;

  srx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (rxd),
    .dout  (rxd_s)
  );

  srx_frame_fsm #(.OSR(OSR), .DW(DW)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .tick        (baud_tick),
    .rxd_s       (rxd_s),
    .nine_bit    (nine_bit_mode),
    .frm_valid   (frm_valid),
    .frm_data    (frm_data),
    .frm_ninth   (frm_ninth),
    .frm_stop_ok (frm_stop_ok)
  );

  srx_addr_match #(.DW(DW)) u_match (
    .rx_byte  (frm_data),
    .own_addr (slave_addr),
    .cmp_mask (addr_mask),
    .hit      (addr_hit)
  );

  assign accept = frm_valid & (~mp_en | (frm_ninth & addr_hit));

  always_comb begin
    data_d = data_q;
    b9_d   = b9_q;
    done_d = done_q;
    fe_d   = fe_q;
    if (accept) begin
      data_d = frm_data;
      b9_d   = frm_ninth;
      done_d = 1'b1;
    end else if (done_clr) begin
      done_d = 1'b0;
    end
    if (frm_valid && !frm_stop_ok) begin
      fe_d = 1'b1;
    end else if (fe_clr) begin
      fe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      data_q <= '0;
      b9_q   <= 1'b0;
      done_q <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      b9_q   <= b9_d;
      done_q <= done_d;
      fe_q   <= fe_d;
    end
  end

  assign rx_data   = data_q;
  assign rx_bit9   = b9_q;
  assign rx_done   = done_q;
  assign frame_err = fe_q;

  // R6: framing error is sticky without a clear strobe
  a_r6_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frame_err && !fe_clr) |=> frame_err);

  // R7: framing error falls only after a clear strobe
  a_r7_fe_fall_needs_clr: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(frame_err) |-> $past(fe_clr));

  // R8: receive-complete rises only on a finished frame
  a_r8_done_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rx_done) |-> $past(frm_valid));

  // R9: a frame without address marker in filtering mode leaves data untouched
  a_r9_mp_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frm_valid && mp_en && !frm_ninth) |=> ($stable(rx_data) && $stable(rx_bit9)));

endmodule

// File: tb/serial_rx_addrfilt_bench.sv
module serial_rx_addrfilt_bench;

  logic       clk;
  logic       rst_n;
  logic       rxd;
  logic       baud_tick;
  logic       nine_bit_mode;
  logic       mp_en;
  logic [7:0] slave_addr;
  logic [7:0] addr_mask;
  logic       done_clr;
  logic       fe_clr;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       rx_done;
  logic       frame_err;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    cmp_on   = 0;
  bit    finished = 0;
  string cur_req  = "R1";

  // behavioural expectation
  logic [7:0] exp_data;
  logic       exp_b9, exp_done, exp_fe;
  logic [7:0] pend_d;
  logic       pend_b9, pend_stop;

  serial_rx_addrfilt u_serial_rx_addrfilt (
    .clk           (clk),
    .rst_n         (rst_n),
    .rxd           (rxd),
    .baud_tick     (baud_tick),
    .nine_bit_mode (nine_bit_mode),
    .mp_en         (mp_en),
    .slave_addr    (slave_addr),
    .addr_mask     (addr_mask),
    .done_clr      (done_clr),
    .fe_clr        (fe_clr),
    .rx_data       (rx_data),
    .rx_bit9       (rx_bit9),
    .rx_done       (rx_done),
    .frame_err     (frame_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      n_checks++;
      if (rx_data !== exp_data || rx_bit9 !== exp_b9 ||
          rx_done !== exp_done || frame_err !== exp_fe) begin
        n_fails++;
        $display("FAIL %s per-cycle: actual %h/%b/%b/%b expected %h/%b/%b/%b", cur_req,
                 rx_data, rx_bit9, rx_done, frame_err, exp_data, exp_b9, exp_done, exp_fe);
      end
    end
  end

  function automatic bit addr_ok(input logic [7:0] d);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (addr_mask[i] && d[i] != slave_addr[i]) ok = 1'b0;
    end
    return ok || (d == (slave_addr | addr_mask));
  endfunction

  task automatic model_frame_end(input bit clr);
    logic marker;
    bit   acc;
    marker = nine_bit_mode ? pend_b9 : pend_stop;
    acc    = !mp_en || (marker && addr_ok(pend_d));
    if (acc) begin
      exp_data = pend_d;
      exp_b9   = marker;
      exp_done = 1'b1;
    end else if (clr) begin
      exp_done = 1'b0;
    end
    if (!pend_stop) exp_fe = 1'b1;
    else if (clr)   exp_fe = 1'b0;
  endtask

  // one baud tick with a chosen line value; entered and left at posedge+1
  task automatic do_tick(input logic v, input bit clr, input bit fin);
    rxd = v;
    @(posedge clk); #1;
    @(posedge clk); #1;
    baud_tick = 1'b1;
    done_clr  = clr;
    fe_clr    = clr;
    @(posedge clk); #1;
    baud_tick = 1'b0;
    done_clr  = 1'b0;
    fe_clr    = 1'b0;
    if (fin) model_frame_end(clr);
  endtask

  task automatic idle_ticks(input int n);
    for (int k = 0; k < n; k++) do_tick(1'b1, 1'b0, 1'b0);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop,
                            input int gl_bit, input bit clr_end);
    logic v;
    pend_d = d; pend_b9 = b9; pend_stop = stop;
    for (int k = 0; k < 16; k++) do_tick(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 16; k++) begin
        v = d[i];
        if (gl_bit == i && k == 8) v = ~v;
        do_tick(v, 1'b0, 1'b0);
      end
    end
    if (nine_bit_mode) begin
      for (int k = 0; k < 16; k++) do_tick(b9, 1'b0, 1'b0);
    end
    for (int k = 0; k < 9; k++) do_tick(stop, 1'b0, 1'b0);
    do_tick(stop, clr_end, 1'b1);
    for (int k = 10; k < 16; k++) do_tick(1'b1, 1'b0, 1'b0);
    idle_ticks(3);
  endtask

  task automatic pulse_clr(input bit dc, input bit fc);
    done_clr = dc;
    fe_clr   = fc;
    @(posedge clk); #1;
    done_clr = 1'b0;
    fe_clr   = 1'b0;
    if (dc) exp_done = 1'b0;
    if (fc) exp_fe   = 1'b0;
  endtask

  task automatic chk_all(input string req, input logic [7:0] d, input logic b9,
                         input logic dn, input logic fe);
    chk(req, "rx_data", int'(rx_data), int'(d));
    chk(req, "rx_bit9", int'(rx_bit9), int'(b9));
    chk(req, "rx_done", int'(rx_done), int'(dn));
    chk(req, "frame_err", int'(frame_err), int'(fe));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; baud_tick = 1'b0; nine_bit_mode = 1'b0; mp_en = 1'b0;
    slave_addr = 8'h00; addr_mask = 8'h00; done_clr = 1'b0; fe_clr = 1'b0;
    exp_data = 8'h00; exp_b9 = 1'b0; exp_done = 1'b0; exp_fe = 1'b0;
    pend_d = 8'h00; pend_b9 = 1'b0; pend_stop = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    // R1 reset state
    chk_all("R1", 8'h00, 1'b0, 1'b0, 1'b0);
    cmp_on = 1;
    idle_ticks(2);

    // R2 / R4: basic 8-bit frame, stop bit lands in rx_bit9
    cur_req = "R2";
    send_frame(8'hA5, 1'b0, 1'b1, -1, 1'b0);
    chk_all("R2", 8'hA5, 1'b1, 1'b1, 1'b0);
    cur_req = "R8";
    pulse_clr(1'b1, 1'b0);
    chk("R8", "rx_done after clear", int'(rx_done), 0);

    // R4 / R6: low stop bit, then a good frame does not clear the error
    cur_req = "R4";
    send_frame(8'h3C, 1'b0, 1'b0, -1, 1'b0);
    chk_all("R4", 8'h3C, 1'b0, 1'b1, 1'b1);
    cur_req = "R6";
    send_frame(8'h0F, 1'b0, 1'b1, -1, 1'b0);
    chk_all("R6", 8'h0F, 1'b1, 1'b1, 1'b1);

    // R7 / R8: clear, then set and clear on the same edge
    cur_req = "R7";
    pulse_clr(1'b0, 1'b1);
    chk("R7", "frame_err after clear", int'(frame_err), 0);
    send_frame(8'h96, 1'b0, 1'b0, -1, 1'b1);
    chk("R7", "frame_err set wins", int'(frame_err), 1);
    chk("R8", "rx_done set wins", int'(rx_done), 1);
    pulse_clr(1'b1, 1'b1);

    // R3: 9-bit frames
    cur_req = "R3";
    nine_bit_mode = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b1, -1, 1'b0);
    chk_all("R3", 8'h5A, 1'b1, 1'b1, 1'b0);
    send_frame(8'hC3, 1'b0, 1'b1, -1, 1'b0);
    chk_all("R3", 8'hC3, 1'b0, 1'b1, 1'b0);

    // R13: one inverted sample inside data bit 3
    cur_req = "R13";
    send_frame(8'h81, 1'b1, 1'b1, 3, 1'b0);
    chk("R13", "rx_data with sample glitch", int'(rx_data), 8'h81);

    // R5: short start pulse is rejected, next frame is intact
    cur_req = "R5";
    for (int k = 0; k < 5; k++) do_tick(1'b0, 1'b0, 1'b0);
    for (int k = 5; k < 16; k++) do_tick(1'b1, 1'b0, 1'b0);
    idle_ticks(4);
    chk("R5", "rx_data after glitch", int'(rx_data), 8'h81);
    send_frame(8'h42, 1'b0, 1'b1, -1, 1'b0);
    chk_all("R5", 8'h42, 1'b0, 1'b1, 1'b0);

    // R9: filtering, marker 0 ignored
    cur_req = "R9";
    pulse_clr(1'b1, 1'b0);
    mp_en = 1'b1; slave_addr = 8'h35; addr_mask = 8'hF0;
    send_frame(8'h35, 1'b0, 1'b1, -1, 1'b0);
    chk_all("R9", 8'h42, 1'b0, 1'b0, 1'b0);

    // R10: masked match accepted, mismatch rejected
    cur_req = "R10";
    send_frame(8'h3A, 1'b1, 1'b1, -1, 1'b0);
    chk_all("R10", 8'h3A, 1'b1, 1'b1, 1'b0);
    pulse_clr(1'b1, 1'b0);
    send_frame(8'h45, 1'b1, 1'b1, -1, 1'b0);
    chk_all("R10", 8'h3A, 1'b1, 1'b0, 1'b0);

    // R11: broadcast address slave_addr|addr_mask = F5
    cur_req = "R11";
    send_frame(8'hF5, 1'b1, 1'b1, -1, 1'b0);
    chk_all("R11", 8'hF5, 1'b1, 1'b1, 1'b0);
    pulse_clr(1'b1, 1'b0);

    // R12: 8-bit filtering uses the stop bit as marker
    cur_req = "R12";
    nine_bit_mode = 1'b0;
    send_frame(8'h31, 1'b0, 1'b0, -1, 1'b0);
    chk_all("R12", 8'hF5, 1'b1, 1'b0, 1'b1);
    send_frame(8'h32, 1'b0, 1'b1, -1, 1'b0);
    chk_all("R12", 8'h32, 1'b1, 1'b1, 1'b1);

    idle_ticks(2);
    cmp_on = 0;
    finish_run();
  end

endmodule